// File: doc/BRIEF.md
# Zero-Turnaround Pipelined Burst SRAM

This block is a synchronous SRAM with a small behavioural storage array behind it. It accepts a new read or write on every rising clock edge, in any order, with no idle cycles between them. Every operation has the same shape. The address and control are sampled on one edge. Two edges later the data moves: read data comes out of an output register, and write data is taken from the input bus. Because both directions use that same latency, a write can follow a read, or a read can follow a write, on the very next cycle.

A write that has captured its data is not put into the array at once. It waits in a one-entry pending stage and is committed on the next enabled edge. A read of that address in the meantime gets the stored word with the pending byte lanes merged over it. The block also provides a clock-enable stall, decoding of three chip selects, a four-beat burst counter with linear or interleaved order, and gating of the output driver so that it is off during the data phase of a write.

Top module: `nb_sram`

## Requirements
- R1: A read whose address is sampled on edge N drives the stored word on `dq_out` just after edge N+2, with `dq_oe` high when `oe` is high.
- R2: A write whose address is sampled on edge N takes `dq_in` on edge N+2. Reads and writes run back to back on every enabled edge without wait states.
- R3: Only the lanes selected in `byte_we` are written. Bit i of `byte_we` covers data bits [9i+8:9i].
- R4: A read of an address whose write is still pending returns the stored word with the pending write's selected lanes merged in.
- R5: While `clk_en` is low, the edge is ignored. All pipeline state, `dq_out` and `dq_oe` hold, and address, control and `dq_in` have no effect.
- R6: A load (`adv_load`=0) starts an access only when `cs1_n`=0, `cs2`=1 and `cs3_n`=0. Otherwise nothing is accessed and `dq_oe` stays low in the matching data phase.
- R7: In the data phase of a write, `dq_oe` is low even when `oe` is high.
- R8: When `oe` is low, `dq_oe` is low at once, with no clock needed, including during a read data phase.
- R9: With `adv_load`=1 after a load, each advance produces the next burst address. The upper bits are kept. The two low bits are (start+beat) mod 4 when `burst_ilv`=0, and start XOR beat when `burst_ilv`=1, where beat counts 1, 2, 3 and then wraps. The operation type of the load is kept for the whole burst.
- R10: An advance that follows a deselected load starts no access.
- R11: After reset, `dq_oe` and `dq_out` are zero and no operation is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| clk_en | input | 1 | Clock qualifier; low stalls the block |
| cs1_n | input | 1 | Chip select, active low |
| cs2 | input | 1 | Chip select, active high |
| cs3_n | input | 1 | Chip select, active low |
| adv_load | input | 1 | 0 loads a new address, 1 advances the burst |
| wr_en | input | 1 | 1 for a write, 0 for a read (used on a load) |
| byte_we | input | LANES | Per-lane write select |
| addr | input | ADDR_W | Word address |
| burst_ilv | input | 1 | Burst order: 0 linear, 1 interleaved |
| oe | input | 1 | Asynchronous output enable, active high |
| dq_in | input | LANES*LANE_W | Write data bus |
| dq_out | output | LANES*LANE_W | Registered read data |
| dq_oe | output | 1 | Read data driver enable |

## Verification
The bench runs long mixed streams. In them a read lands one edge after a write to the same address, with partial lane masks, so a design without merging of the pending write would return the old word, or would lose the lanes that were not selected. Bursts are swept over every start offset, in both orders and for both operation types. A counter that carries into the upper address bits, or that mixes up linear and interleaved order, would read from the wrong words. Stalls are placed inside a running pipeline while junk is driven on the inputs. A design that still captured data, or that moved its output register, would shift or corrupt later results. Deselected loads and dead advances check that no stray drive appears on the bus.

// File: rtl/nb_pkg.sv
package nb_pkg;
  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } op_e;

  // Low two address bits of a burst beat, relative to the starting offset.
  function automatic logic [1:0] beat_offset(input logic [1:0] start,
                                             input logic [1:0] beat,
                                             input logic       ilv);
    return ilv ? (start ^ beat) : (start + beat);
  endfunction
endpackage

// File: rtl/nb_burst.sv
module nb_burst #(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clk_en,
  input  logic              sel_ok,
  input  logic              adv_load,
  input  logic              wr_en,
  input  logic              burst_ilv,
  input  logic [ADDR_W-1:0] addr,
  input  logic [LANES-1:0]  byte_we,
  output nb_pkg::op_e       s1_op,
  output logic [ADDR_W-1:0] s1_addr,
  output logic [LANES-1:0]  s1_mask
);
  import nb_pkg::*;
  localparam int HI_W = ADDR_W - 2;

  logic [HI_W-1:0]   base_hi, n_base;
  logic [1:0]        start_off, n_start, beat, n_beat;
  logic              burst_wr, n_wr, live, n_live;
  op_e               n_op;
  logic [ADDR_W-1:0] n_addr;
  logic [1:0]        adv_beat, adv_off;
  logic              adv_dead;

  assign adv_beat = beat + 2'd1;
  assign adv_off  = beat_offset(start_off, adv_beat, burst_ilv);
  assign adv_dead = adv_load & ~live;

  always_comb begin
    n_op    = OP_IDLE;
    n_addr  = s1_addr;
    n_base  = base_hi;
    n_start = start_off;
    n_beat  = beat;
    n_wr    = burst_wr;
    n_live  = live;
    if (!adv_load) begin
      n_addr = addr;
      if (sel_ok) begin
        n_op    = wr_en ? OP_WRITE : OP_READ;
        n_base  = addr[ADDR_W-1:2];
        n_start = addr[1:0];
        n_beat  = 2'd0;
        n_wr    = wr_en;
        n_live  = 1'b1;
      end else begin
        n_live = 1'b0;
      end
    end else if (live) begin
      n_op   = burst_wr ? OP_WRITE : OP_READ;
      n_addr = {base_hi, adv_off};
      n_beat = adv_beat;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_op     <= OP_IDLE;
      s1_addr   <= '0;
      s1_mask   <= '0;
      base_hi   <= '0;
      start_off <= '0;
      beat      <= '0;
      burst_wr  <= 1'b0;
      live      <= 1'b0;
    end else if (clk_en) begin
      s1_op     <= n_op;
      s1_addr   <= n_addr;
      s1_mask   <= byte_we;
      base_hi   <= n_base;
      start_off <= n_start;
      beat      <= n_beat;
      burst_wr  <= n_wr;
      live      <= n_live;
    end
  end

  a_r10_dead_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en && adv_dead) |=> (s1_op == OP_IDLE));
  a_r6_deselect_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en && !adv_load && !sel_ok) |=> (s1_op == OP_IDLE));
  a_r9_upper_held: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en && adv_load && live) |=>
      (s1_addr[ADDR_W-1:2] == $past(s1_addr[ADDR_W-1:2])));
endmodule

// File: rtl/nb_mem.sv
module nb_mem #(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                      clk,
  input  logic                      wr_go,
  input  logic [ADDR_W-1:0]         wr_addr,
  input  logic [LANES*LANE_W-1:0]   wr_data,
  input  logic [LANES-1:0]          wr_mask,
  input  logic [ADDR_W-1:0]         rd_addr,
  output logic [LANES*LANE_W-1:0]   rd_data
);
  localparam int DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] bank [DEPTH];
    always_ff @(posedge clk) begin
      if (wr_go && wr_mask[g]) bank[wr_addr] <= wr_data[g*LANE_W +: LANE_W];
    end
    assign rd_data[g*LANE_W +: LANE_W] = bank[rd_addr];
  end
endmodule

// File: rtl/nb_wpipe.sv
module nb_wpipe #(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clk_en,
  input  nb_pkg::op_e             s1_op,
  input  logic [ADDR_W-1:0]       s1_addr,
  input  logic [LANES-1:0]        s1_mask,
  input  logic [LANES*LANE_W-1:0] dq_in,
  input  logic [LANES*LANE_W-1:0] mem_rd,
  output nb_pkg::op_e             s2_op,
  output logic [ADDR_W-1:0]       s2_addr,
  output logic [LANES*LANE_W-1:0] rd_word,
  output logic                    wr_go,
  output logic [ADDR_W-1:0]       wr_addr,
  output logic [LANES*LANE_W-1:0] wr_data,
  output logic [LANES-1:0]        wr_mask
);
  import nb_pkg::*;
  localparam int DATA_W = LANES * LANE_W;

  logic [LANES-1:0]  s2_mask;
  logic              pend_v;
  logic [ADDR_W-1:0] pend_addr;
  logic [DATA_W-1:0] pend_data;
  logic [LANES-1:0]  pend_mask;
  logic              pend_hit;

  function automatic logic [DATA_W-1:0] lane_merge(input logic [DATA_W-1:0] base,
                                                   input logic [DATA_W-1:0] over,
                                                   input logic [LANES-1:0]  sel);
    logic [DATA_W-1:0] r;
    r = base;
    for (int l = 0; l < LANES; l++)
      if (sel[l]) r[l*LANE_W +: LANE_W] = over[l*LANE_W +: LANE_W];
    return r;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s2_op     <= OP_IDLE;
      s2_addr   <= '0;
      s2_mask   <= '0;
      pend_v    <= 1'b0;
      pend_addr <= '0;
      pend_data <= '0;
      pend_mask <= '0;
    end else if (clk_en) begin
      s2_op   <= s1_op;
      s2_addr <= s1_addr;
      s2_mask <= s1_mask;
      pend_v  <= (s2_op == OP_WRITE);
      if (s2_op == OP_WRITE) begin
        pend_addr <= s2_addr;
        pend_data <= dq_in;
        pend_mask <= s2_mask;
      end
    end
  end

  assign pend_hit = pend_v && (pend_addr == s2_addr);
  assign rd_word  = lane_merge(mem_rd, pend_data, pend_hit ? pend_mask : '0);
  assign wr_go    = clk_en & pend_v;
  assign wr_addr  = pend_addr;
  assign wr_data  = pend_data;
  assign wr_mask  = pend_mask;

  a_r2_stage_advance: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en |=> (s2_op == $past(s1_op)));
  a_r4_full_forward: assert property (@(posedge clk) disable iff (!rst_n)
    (s2_op == OP_READ && pend_hit && (&pend_mask)) |-> (rd_word == pend_data));
endmodule

// File: rtl/nb_sram.sv
module nb_sram #(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clk_en,
  input  logic                    cs1_n,
  input  logic                    cs2,
  input  logic                    cs3_n,
  input  logic                    adv_load,
  input  logic                    wr_en,
  input  logic [LANES-1:0]        byte_we,
  input  logic [ADDR_W-1:0]       addr,
  input  logic                    burst_ilv,
  input  logic                    oe,
  input  logic [LANES*LANE_W-1:0] dq_in,
  output logic [LANES*LANE_W-1:0] dq_out,
  output logic                    dq_oe
);
  import nb_pkg::*;
  localparam int DATA_W = LANES * LANE_W;

  logic              sel_ok;
  op_e               s1_op, s2_op;
  logic [ADDR_W-1:0] s1_addr, s2_addr, wr_addr;
  logic [LANES-1:0]  s1_mask, wr_mask;
  logic [DATA_W-1:0] mem_rd, rd_word, wr_data;
  logic              wr_go;
  logic              drive_rd, phase_wr;

  assign sel_ok = ~cs1_n & cs2 & ~cs3_n;

  nb_burst #(.ADDR_W(ADDR_W), .LANES(LANES)) u_burst (
    .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .sel_ok(sel_ok),
    .adv_load(adv_load), .wr_en(wr_en), .burst_ilv(burst_ilv),
    .addr(addr), .byte_we(byte_we),
    .s1_op(s1_op), .s1_addr(s1_addr), .s1_mask(s1_mask));

  nb_wpipe #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_wpipe (
    .clk(clk), .rst_n(rst_n), .clk_en(clk_en),
    .s1_op(s1_op), .s1_addr(s1_addr), .s1_mask(s1_mask),
    .dq_in(dq_in), .mem_rd(mem_rd),
    .s2_op(s2_op), .s2_addr(s2_addr), .rd_word(rd_word),
    .wr_go(wr_go), .wr_addr(wr_addr), .wr_data(wr_data), .wr_mask(wr_mask));

  nb_mem #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_mem (
    .clk(clk), .wr_go(wr_go), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_mask(wr_mask), .rd_addr(s2_addr), .rd_data(mem_rd));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dq_out   <= '0;
      drive_rd <= 1'b0;
      phase_wr <= 1'b0;
    end else if (clk_en) begin
      drive_rd <= (s2_op == OP_READ);
      phase_wr <= (s2_op == OP_WRITE);
      if (s2_op == OP_READ) dq_out <= rd_word;
    end
  end

  assign dq_oe = oe & drive_rd;

  a_r7_write_phase_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    phase_wr |-> !dq_oe);
  a_r5_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_en |=> ($stable(dq_out) && $stable(drive_rd) && $stable(phase_wr)));
endmodule

// File: tb/nb_sram_bench.sv
`timescale 1ns/1ps
module nb_sram_bench;
  localparam int AW = 8, LN = 4, LW = 9, DW = LN * LW, DEPTH = 1 << AW;

  logic clk = 1'b0, rst_n = 1'b0, clk_en = 1'b0;
  logic cs1_n = 1'b1, cs2 = 1'b0, cs3_n = 1'b1, adv_load = 1'b0, wr_en = 1'b0;
  logic [LN-1:0] byte_we = '0;
  logic [AW-1:0] addr = '0;
  logic burst_ilv = 1'b0, oe = 1'b1;
  logic [DW-1:0] dq_in = '0, dq_out;
  logic dq_oe;

  always #2 clk = ~clk;

  nb_sram #(.ADDR_W(AW), .LANES(LN), .LANE_W(LW)) u_nb_sram (
    .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .cs1_n(cs1_n), .cs2(cs2),
    .cs3_n(cs3_n), .adv_load(adv_load), .wr_en(wr_en), .byte_we(byte_we),
    .addr(addr), .burst_ilv(burst_ilv), .oe(oe), .dq_in(dq_in),
    .dq_out(dq_out), .dq_oe(dq_oe));

  logic [DW-1:0] model [DEPTH];
  int n_chk = 0, n_err = 0, sc = 0;
  int h_kind [3];
  logic [DW-1:0] h_exp [3], h_wd [3];
  string h_tag [3];
  logic [AW-3:0] bb_hi;
  logic [1:0] bb_start, bb_beat;
  bit bb_wr, bb_live;
  logic [31:0] lfsr = 32'hACE1_2468;

  function automatic logic [31:0] rnd_next(input logic [31:0] v);
    return {v[30:0], v[31] ^ v[21] ^ v[1] ^ v[0]};
  endfunction

  function automatic logic [1:0] b_off(input logic [1:0] s, input logic [1:0] b, input bit ilv);
    if (ilv) return {s[1] ^ b[1], s[0] ^ b[0]};
    return 2'((int'(s) + int'(b)) % 4);
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic step(input bit sel, input bit adv, input bit wr,
                      input logic [AW-1:0] a, input logic [LN-1:0] be, input string tag);
    int kind;
    logic [AW-1:0] ea;
    logic [DW-1:0] wd, ex;
    bit want_oe;
    string otag;
    // check the command issued three steps ago
    kind = h_kind[2];
    want_oe = (kind == 1) && oe;
    otag = (kind == 0) ? "R6" : (kind == 2) ? "R7" : (!oe ? "R8" : h_tag[2]);
    check(dq_oe === want_oe, otag, "dq_oe", DW'(dq_oe), DW'(want_oe));
    if (want_oe) check(dq_out === h_exp[2], h_tag[2], "dq_out", dq_out, h_exp[2]);
    // bench view of the new command
    ea = a;
    if (!adv) begin
      if (sel) begin
        kind = wr ? 2 : 1; bb_live = 1; bb_beat = 0;
        bb_start = a[1:0]; bb_hi = a[AW-1:2]; bb_wr = wr;
      end else begin
        kind = 0; bb_live = 0;
      end
    end else if (bb_live) begin
      bb_beat = bb_beat + 2'd1;
      ea = {bb_hi, b_off(bb_start, bb_beat, burst_ilv)};
      kind = bb_wr ? 2 : 1;
    end else kind = 0;
    wd = {16'(sc * 40503), 12'(sc * 7 + 3), ea};
    ex = '0;
    if (kind == 2)
      for (int l = 0; l < LN; l++) if (be[l]) model[ea][l*LW +: LW] = wd[l*LW +: LW];
    if (kind == 1) ex = model[ea];
    for (int k = 2; k > 0; k--) begin
      h_kind[k] = h_kind[k-1]; h_exp[k] = h_exp[k-1];
      h_wd[k] = h_wd[k-1]; h_tag[k] = h_tag[k-1];
    end
    h_kind[0] = kind; h_exp[0] = ex; h_wd[0] = wd; h_tag[0] = tag;
    clk_en = 1'b1;
    cs1_n = 1'b0; cs2 = 1'b1; cs3_n = 1'b0;
    if (!sel) begin
      case (sc % 3)
        0: cs1_n = 1'b1;
        1: cs2 = 1'b0;
        default: cs3_n = 1'b1;
      endcase
    end
    adv_load = adv; wr_en = wr; byte_we = be; addr = a;
    dq_in = h_wd[2];
    sc++;
    @(posedge clk); @(negedge clk);
  endtask

  task automatic stall();
    logic [DW-1:0] so;
    logic soe;
    so = dq_out; soe = dq_oe;
    clk_en = 1'b0;
    addr = ~addr; wr_en = ~wr_en; adv_load = ~adv_load; byte_we = ~byte_we;
    dq_in = ~dq_in; cs1_n = 1'b0; cs2 = 1'b1; cs3_n = 1'b0;
    @(posedge clk); @(negedge clk);
    check(dq_out === so, "R5", "dq_out held in stall", dq_out, so);
    check(dq_oe === soe, "R5", "dq_oe held in stall", DW'(dq_oe), DW'(soe));
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, '0, '0, "R6");
  endtask

  initial begin
    for (int k = 0; k < 3; k++) begin h_kind[k] = 0; h_exp[k] = '0; h_wd[k] = '0; h_tag[k] = "R1"; end
    bb_live = 0; bb_hi = '0; bb_start = '0; bb_beat = '0; bb_wr = 0;
    repeat (3) @(negedge clk);
    check(dq_oe === 1'b0, "R11", "dq_oe in reset", DW'(dq_oe), '0);
    check(dq_out === '0, "R11", "dq_out in reset", dq_out, '0);
    rst_n = 1'b1;
    @(negedge clk);
    check(dq_oe === 1'b0, "R11", "dq_oe after reset", DW'(dq_oe), '0);

    // R2: fill back to back, then R1: read all back to back
    for (int i = 0; i < DEPTH; i++) step(1, 0, 1, AW'(i), '1, "R2");
    for (int i = 0; i < DEPTH; i++) step(1, 0, 0, AW'(i), '1, "R1");

    // R3/R4: alternating writes and reads, often hitting the write just issued
    for (int i = 0; i < 500; i++) begin
      logic [AW-1:0] wa;
      lfsr = rnd_next(lfsr);
      wa = lfsr[AW-1:0];
      step(1, 0, 1, wa, lfsr[11:8], "R3");
      lfsr = rnd_next(lfsr);
      if (lfsr[0]) step(1, 0, 0, wa, '0, "R4");
      else step(1, 0, 0, lfsr[AW:1], '0, "R2");
    end

    // R9: bursts, every start offset, both orders, write then read back
    for (int m = 0; m < 2; m++) begin
      burst_ilv = m[0];
      for (int s = 0; s < 4; s++) begin
        logic [AW-1:0] ba;
        ba = AW'(8'h40 + s + 8 * (m * 4 + s));
        step(1, 0, 1, ba, 4'hF, "R9");
        for (int b = 0; b < 3; b++) step(0, 1, 0, '0, LN'(4'hF ^ (b + 1)), "R9");
        step(1, 0, 0, ba, '0, "R9");
        for (int b = 0; b < 3; b++) step(0, 1, 1, '0, '1, "R9");
      end
    end
    burst_ilv = 1'b0;
    idle(3);

    // R6/R10: deselected loads and dead advances
    for (int i = 0; i < 6; i++) begin
      step(0, 0, 1, AW'(i * 5), '1, "R6");
      step(0, 1, 1, '0, '1, "R10");
      step(0, 1, 0, '0, '1, "R10");
    end
    step(1, 0, 0, 8'h13, '0, "R1");
    step(0, 1, 0, '0, '0, "R9");
    idle(3);

    // R5: stalls inside a busy mixed stream
    for (int i = 0; i < 90; i++) begin
      lfsr = rnd_next(lfsr);
      step(1, 0, lfsr[3], lfsr[AW+3:4], lfsr[15:12], "R5");
      if (lfsr[20] | lfsr[21]) stall();
    end
    idle(3);

    // R8: output enable low during reads; R7 during writes with oe high
    oe = 1'b0;
    for (int i = 0; i < 6; i++) step(1, 0, 0, AW'(i), '0, "R8");
    idle(3);
    oe = 1'b1;
    for (int i = 0; i < 6; i++) step(1, 0, 1, AW'(i + 100), '1, "R7");
    idle(4);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #(4 * 200000);
    n_chk++; n_err++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule